// File: doc/BRIEF.md
# Folded-Tap Decimating FIR Cell

This block is an 8-tap FIR filter cell for 10-bit two's-complement samples and 10-bit two's-complement coefficients. In folded mode, the cell adds each pair of samples that sit at mirrored positions in the delay line before multiplying. A symmetric impulse response then needs only four coefficient products per sample. In general mode, each of the eight taps has its own coefficient. This mode serves asymmetric responses.

A bank holds 32 coefficient sets of eight entries each. The set is chosen by a select input that is sampled together with every input sample, so polyphase and adaptive schemes can change sets on any clock. Software loads the bank through a write port: it places the word at `set * 8 + tap` and the write lands on the clock edge. The cell decimates by a factor D between 1 and 16. It sums the tap sums of D consecutive samples into a full-precision accumulator and gives one result per D samples.

Top module: `sym_fir_cell`

## Requirements
- R1: While `rst_ni` is low, `acc_vld_o` is 0 and `acc_o` is 0.
- R2: With `sym_mode_i`=1 and D=1, each result is c[0]*(x[n]+x[n-7]) + c[1]*(x[n-1]+x[n-6]) + c[2]*(x[n-2]+x[n-5]) + c[3]*(x[n-3]+x[n-4]). Here x[n] is the sample taken with the valid strobe, x[n-k] is the k-th earlier valid sample (0 after reset), and c[k] is tap k of the selected set.
- R3: With `sym_mode_i`=0 and D=1, each result is the sum over k=0..7 of c[k]*x[n-k].
- R4: D = `decim_m1_i`+1. Exactly one `acc_vld_o` pulse follows each group of D valid samples. The result is the sum of the D per-sample tap sums of that group, each computed in the mode given with its sample.
- R5: The coefficient set for a sample is the value of `set_sel_i` in the same cycle as that sample's `sample_vld_i`, and it may differ on every clock.
- R6: A write with `coef_we_i`=1 stores `coef_data_i` at set `coef_addr_i[7:3]`, tap `coef_addr_i[2:0]` on the rising edge. A sample taken in that same cycle still uses the old word, and later samples use the new one.
- R7: Cycles without `sample_vld_i` do not advance the delay line or the decimation phase. Between pulses, `acc_o` holds the last result.
- R8: Results are exact, without wrap, for the extreme input -512 on all samples and coefficients with D=16 in either mode (33554432).
- R9: In folded mode, taps 4 to 7 of a set have no effect on the result.
- R10: A result is presented on `acc_vld_o` two clock edges after the edge that takes the last sample of its group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 10 | Input sample, two's complement |
| sample_vld_i | input | 1 | Sample strobe |
| sym_mode_i | input | 1 | 1 = folded (symmetric), 0 = general |
| decim_m1_i | input | 4 | Decimation factor minus one |
| set_sel_i | input | 5 | Coefficient set for this sample |
| coef_we_i | input | 1 | Coefficient write strobe |
| coef_addr_i | input | 8 | Write address, set*8+tap |
| coef_data_i | input | 10 | Coefficient word, two's complement |
| acc_o | output | 28 | Accumulated result |
| acc_vld_o | output | 1 | Result strobe, one cycle |

## Verification
A delay-line word that is off by one position, or a wrong pairing of mirrored taps, changes the very next result. That result appears two edges after the sample. A decimation phase counter that drifts shows up in the next group as a missing, extra or early pulse, and the sum folds in the wrong number of phases. A corrupted bank word or a wrong set decode shows up only on samples that select the damaged set. For that reason the sweep walks the select across all 32 sets within each decimation setting.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam int unsigned SFC_DATA_W    = 10;
  localparam int unsigned SFC_COEF_W    = 10;
  localparam int unsigned SFC_TAPS      = 8;
  localparam int unsigned SFC_NUM_SETS  = 32;
  localparam int unsigned SFC_MAX_DECIM = 16;

  typedef enum logic {
    FOLD_OFF = 1'b0,
    FOLD_ON  = 1'b1
  } fold_mode_e;
endpackage

// File: rtl/sfc_coef_bank.sv
module sfc_coef_bank #(
  parameter  int unsigned COEF_W   = 10,
  parameter  int unsigned TAPS     = 8,
  parameter  int unsigned NUM_SETS = 32,
  localparam int unsigned TAP_W    = $clog2(TAPS),
  localparam int unsigned SET_W    = $clog2(NUM_SETS),
  localparam int unsigned ADDR_W   = SET_W + TAP_W,
  localparam int unsigned DEPTH    = NUM_SETS * TAPS
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [ADDR_W-1:0]            waddr_i,
  input  logic [COEF_W-1:0]            wdata_i,
  input  logic [SET_W-1:0]             rsel_i,
  output logic [TAPS-1:0][COEF_W-1:0]  coef_o
);
  logic [COEF_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  // whole set read in parallel; same-cycle write is seen one edge later
  for (genvar t = 0; t < int'(TAPS); t++) begin : g_rd
    assign coef_o[t] = mem_q[{rsel_i, TAP_W'(t)}];
  end
endmodule

// File: rtl/sfc_tap_slice.sv
module sfc_tap_slice #(
  parameter  int unsigned DATA_W = 10,
  parameter  int unsigned COEF_W = 10,
  localparam int unsigned PRE_W  = DATA_W + 1,
  localparam int unsigned PROD_W = DATA_W + COEF_W + 1
) (
  input  logic                     fold_i,
  input  logic signed [DATA_W-1:0] near_i,
  input  logic signed [DATA_W-1:0] far_i,
  input  logic signed [COEF_W-1:0] c_near_i,
  input  logic signed [COEF_W-1:0] c_far_i,
  output logic signed [PROD_W-1:0] prod_o
);
  logic signed [PRE_W-1:0]  near_ext, far_ext, pre_sum;
  logic signed [PROD_W-1:0] pre_w, far_w, cn_w, cf_w;
  logic signed [PROD_W-1:0] m_near, m_far;

  assign near_ext = near_i;
  assign far_ext  = far_i;
  assign pre_sum  = fold_i ? near_ext + far_ext : near_ext;

  assign pre_w = pre_sum;
  assign far_w = far_ext;
  assign cn_w  = c_near_i;
  assign cf_w  = c_far_i;

  assign m_near = pre_w * cn_w;
  // second product only contributes in general mode
  assign m_far  = fold_i ? '0 : far_w * cf_w;
  assign prod_o = m_near + m_far;
endmodule

// File: rtl/sfc_decim_acc.sv
module sfc_decim_acc #(
  parameter int unsigned SUM_W = 24,
  parameter int unsigned ACC_W = 28,
  parameter int unsigned CNT_W = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [SUM_W-1:0] sum_i,
  input  logic                    vld_i,
  input  logic [CNT_W-1:0]        decim_m1_i,
  output logic signed [ACC_W-1:0] acc_o,
  output logic                    vld_o
);
  logic [CNT_W-1:0]        cnt_q;
  logic signed [SUM_W-1:0] sum_q;
  logic                    sv_q, last_q;
  logic signed [ACC_W-1:0] part_q, acc_q, acc_total;
  logic                    out_vld_q;
  logic                    frame_end;

  // >= so a factor lowered mid-group closes the group at once
  assign frame_end = cnt_q >= decim_m1_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sum_q  <= '0;
      sv_q   <= 1'b0;
      last_q <= 1'b0;
    end else begin
      sv_q <= vld_i;
      if (vld_i) begin
        cnt_q  <= frame_end ? '0 : cnt_q + 1'b1;
        sum_q  <= sum_i;
        last_q <= frame_end;
      end
    end
  end

  assign acc_total = part_q + ACC_W'(sum_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      part_q    <= '0;
      acc_q     <= '0;
      out_vld_q <= 1'b0;
    end else begin
      out_vld_q <= sv_q && last_q;
      if (sv_q) begin
        if (last_q) begin
          acc_q  <= acc_total;
          part_q <= '0;
        end else begin
          part_q <= acc_total;
        end
      end
    end
  end

  assign acc_o = acc_q;
  assign vld_o = out_vld_q;
endmodule

// File: rtl/sym_fir_cell.sv
module sym_fir_cell
  import sfc_pkg::*;
#(
  parameter  int unsigned DATA_W    = SFC_DATA_W,
  parameter  int unsigned COEF_W    = SFC_COEF_W,
  parameter  int unsigned TAPS      = SFC_TAPS,
  parameter  int unsigned NUM_SETS  = SFC_NUM_SETS,
  parameter  int unsigned MAX_DECIM = SFC_MAX_DECIM,
  localparam int unsigned HALF      = TAPS / 2,
  localparam int unsigned SET_W     = $clog2(NUM_SETS),
  localparam int unsigned ADDR_W    = SET_W + $clog2(TAPS),
  localparam int unsigned CNT_W     = $clog2(MAX_DECIM),
  localparam int unsigned PROD_W    = DATA_W + COEF_W + 1,
  localparam int unsigned SUM_W     = PROD_W + $clog2(TAPS),
  localparam int unsigned ACC_W     = SUM_W + CNT_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic signed [DATA_W-1:0] sample_i,
  input  logic                     sample_vld_i,
  input  logic                     sym_mode_i,
  input  logic [CNT_W-1:0]         decim_m1_i,
  input  logic [SET_W-1:0]         set_sel_i,
  input  logic                     coef_we_i,
  input  logic [ADDR_W-1:0]        coef_addr_i,
  input  logic [COEF_W-1:0]        coef_data_i,
  output logic signed [ACC_W-1:0]  acc_o,
  output logic                     acc_vld_o
);
  fold_mode_e mode;
  logic       fold;
  assign mode = fold_mode_e'(sym_mode_i);
  assign fold = (mode == FOLD_ON);

  logic [TAPS-1:0][COEF_W-1:0] coef_set;

  sfc_coef_bank #(
    .COEF_W  (COEF_W),
    .TAPS    (TAPS),
    .NUM_SETS(NUM_SETS)
  ) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (coef_we_i),
    .waddr_i(coef_addr_i),
    .wdata_i(coef_data_i),
    .rsel_i (set_sel_i),
    .coef_o (coef_set)
  );

  // dly_q[k] holds the (k+1)-th previous accepted sample
  logic signed [DATA_W-1:0] dly_q [TAPS-1];
  logic signed [DATA_W-1:0] win   [TAPS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < int'(TAPS) - 1; k++) dly_q[k] <= '0;
    end else if (sample_vld_i) begin
      dly_q[0] <= sample_i;
      for (int k = 1; k < int'(TAPS) - 1; k++) dly_q[k] <= dly_q[k-1];
    end
  end

  assign win[0] = sample_i;
  for (genvar k = 1; k < int'(TAPS); k++) begin : g_win
    assign win[k] = dly_q[k-1];
  end

  logic signed [PROD_W-1:0] slice_prod [HALF];

  for (genvar k = 0; k < int'(HALF); k++) begin : g_slice
    sfc_tap_slice #(
      .DATA_W(DATA_W),
      .COEF_W(COEF_W)
    ) u_slice (
      .fold_i  (fold),
      .near_i  (win[k]),
      .far_i   (win[TAPS-1-k]),
      .c_near_i(coef_set[k]),
      .c_far_i (coef_set[TAPS-1-k]),
      .prod_o  (slice_prod[k])
    );
  end

  logic signed [SUM_W-1:0] tap_sum;

  always_comb begin
    tap_sum = '0;
    for (int k = 0; k < int'(HALF); k++) tap_sum = tap_sum + SUM_W'(slice_prod[k]);
  end

  sfc_decim_acc #(
    .SUM_W(SUM_W),
    .ACC_W(ACC_W),
    .CNT_W(CNT_W)
  ) u_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sum_i     (tap_sum),
    .vld_i     (sample_vld_i),
    .decim_m1_i(decim_m1_i),
    .acc_o     (acc_o),
    .vld_o     (acc_vld_o)
  );
endmodule

// File: rtl/sym_fir_cell_chk.sv
module sym_fir_cell_chk #(
  parameter int unsigned ACC_W = 28,
  parameter int unsigned CNT_W = 4
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    sample_vld_i,
  input logic [CNT_W-1:0]        decim_m1_i,
  input logic signed [ACC_W-1:0] acc_o,
  input logic                    acc_vld_o
);
  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_quiet_chk: assert (!acc_vld_o && acc_o == '0);
    end
  end

  // R10
  pulse_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_vld_o |-> ($past(sample_vld_i, 2) && $past(rst_ni, 2)));

  // R4
  unit_decim_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(sample_vld_i, 2) && $past(rst_ni, 2) && $past(decim_m1_i, 2) == '0) |-> acc_vld_o);

  // R7
  hold_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_vld_o |-> $stable(acc_o));
endmodule

bind sym_fir_cell sym_fir_cell_chk #(
  .ACC_W(ACC_W),
  .CNT_W(CNT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sample_vld_i(sample_vld_i),
  .decim_m1_i  (decim_m1_i),
  .acc_o       (acc_o),
  .acc_vld_o   (acc_vld_o)
);

// File: tb/sym_fir_cell_tb.sv
`timescale 1ns/1ps
module sym_fir_cell_tb;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic signed [9:0] sample = '0;
  logic              vld = 1'b0;
  logic              sym = 1'b0;
  logic [3:0]        dm1 = '0;
  logic [4:0]        sel = '0;
  logic              we = 1'b0;
  logic [7:0]        addr = '0;
  logic [9:0]        wdata = '0;
  logic signed [27:0] acc;
  logic              acc_vld;

  always #2 clk = ~clk;

  sym_fir_cell u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sample_i(sample), .sample_vld_i(vld),
    .sym_mode_i(sym), .decim_m1_i(dm1), .set_sel_i(sel), .coef_we_i(we),
    .coef_addr_i(addr), .coef_data_i(wdata), .acc_o(acc), .acc_vld_o(acc_vld)
  );

  int      errors = 0;
  int      checks = 0;
  bit      done = 1'b0;
  longint  cm [256];
  longint  hist [8];
  longint  acc_m = 0;
  int      cnt_m = 0;
  longint  exp_q [$];
  int      tag_q [$];
  longint  last_val = 0;

  function automatic string tname(int t);
    case (t)
      1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
      5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
      9: return "R9";   default: return "R10";
    endcase
  endfunction

  task automatic check(bit ok, int t, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tname(t), act, expv);
    end
  endtask

  function automatic longint cfn(int a);
    return longint'((a * 53 + 17) % 1024) - 512;
  endfunction

  function automatic longint sfn(int i, int d, int s);
    return longint'((i * 37 + d * 11 + s * 5 + 3) % 1024) - 512;
  endfunction

  always @(negedge clk) begin
    if (rst_n && acc_vld) begin
      if (exp_q.size() == 0) begin
        check(1'b0, 4, acc, 0);
      end else begin
        longint e;
        int     t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(acc == e, t, acc, e);
        last_val = e;
      end
    end
  end

  task automatic idle();
    @(negedge clk);
    vld = 1'b0;
    we  = 1'b0;
  endtask

  task automatic wr(int a, longint v);
    @(negedge clk);
    vld = 1'b0; we = 1'b1; addr = 8'(a); wdata = v[9:0];
    cm[a] = v;
  endtask

  task automatic send(longint x, int s, bit fm, int d1, int t,
                      bit wen = 1'b0, int wa = 0, longint wv = 0);
    longint ts;
    @(negedge clk);
    sample = x[9:0]; vld = 1'b1; sel = 5'(s); sym = fm; dm1 = 4'(d1);
    we = wen; addr = 8'(wa); wdata = wv[9:0];
    for (int k = 7; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = x;
    ts = 0;
    if (fm) begin
      for (int k = 0; k < 4; k++) ts += cm[s*8+k] * (hist[k] + hist[7-k]);
    end else begin
      for (int k = 0; k < 8; k++) ts += cm[s*8+k] * hist[k];
    end
    acc_m += ts;
    if (cnt_m >= d1) begin
      exp_q.push_back(acc_m);
      tag_q.push_back(t);
      acc_m = 0;
      cnt_m = 0;
    end else begin
      cnt_m++;
    end
    if (wen) cm[wa] = wv;
  endtask

  initial begin
    for (int k = 0; k < 8; k++) hist[k] = 0;
    for (int a = 0; a < 256; a++) cm[a] = 0;
    repeat (3) @(negedge clk);
    check(acc_vld == 1'b0 && acc == '0, 1, acc, 0);  // R1
    rst_n = 1'b1;

    for (int a = 0; a < 256; a++) wr(a, cfn(a));

    // R2 R3 R4 R5: both modes, every factor, set walks each sample
    for (int s = 0; s < 2; s++) begin
      for (int d = 1; d <= 16; d++) begin
        for (int i = 0; i < 3 * d; i++) begin
          send(sfn(i, d, s), (i * 7 + d) % 32, s[0], d - 1,
               d == 1 ? (s == 1 ? 2 : 3) : 4);
        end
      end
    end

    // R5: alternate extreme sets every clock
    for (int i = 0; i < 16; i++) send(sfn(i, 2, 1), (i % 2) * 31, i[1], 1, 5);

    // R7: gaps between samples
    for (int i = 0; i < 12; i++) begin
      send(sfn(i, 3, 0), 9, 1'b0, 2, 7);
      for (int g = 0; g < i % 3; g++) idle();
    end
    repeat (5) idle();
    check(acc_vld == 1'b0 && acc == last_val, 7, acc, last_val);

    // R6: write during use, then use
    send(sfn(1, 6, 0), 5, 1'b0, 0, 6, 1'b1, 5 * 8 + 0, 300);
    send(sfn(2, 6, 0), 5, 1'b0, 0, 6, 1'b1, 5 * 8 + 7, -301);
    for (int i = 0; i < 4; i++) send(sfn(i, 7, 0), 5, 1'b0, 0, 6);

    // R9: junk in the upper taps of a folded set
    for (int k = 4; k < 8; k++) wr(3 * 8 + k, (k % 2) ? 511 : -512);
    for (int i = 0; i < 10; i++) send(sfn(i, 9, 1), 3, 1'b1, 0, 9);

    // R8: extreme values with the largest factor
    for (int k = 0; k < 8; k++) wr(31 * 8 + k, -512);
    for (int i = 0; i < 8; i++) send(-512, 31, 1'b0, 0, 8);
    for (int i = 0; i < 16; i++) send(-512, 31, 1'b0, 15, 8);
    for (int i = 0; i < 16; i++) send(-512, 31, 1'b1, 15, 8);
    repeat (4) idle();
    check(last_val == 64'sd33554432 && acc == 28'sd33554432, 8, acc, 33554432);

    // R10: exact latency
    send(sfn(5, 10, 0), 12, 1'b0, 0, 10);
    idle();
    check(acc_vld == 1'b0, 10, acc_vld, 0);
    idle();
    check(acc_vld == 1'b1, 10, acc_vld, 1);

    repeat (4) idle();
    check(exp_q.size() == 0, 4, exp_q.size(), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R4 watchdog act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule